// File: doc/BRIEF.md
# Parallel flash command sequencer

This block runs one operation at a time against a byte-wide parallel NOR flash. It supports three operations: byte program, sector erase and manufacturer-ID read. The host latches an operation code, a target address, a data byte, a sector mask and the device's manufacturer ID with a one-cycle start strobe. The block then emits the unlock write cycles for that operation on a simple write/read port, one cycle per write.

Program and erase finish with data polling. The target address is read again and again until bit 7 of the returned byte equals the expected bit 7. For a program that is bit 7 of the data byte; for an erase it is bit 7 of 80h. Before polling starts, an erase waits a fixed settle time. Reads are spaced by a fixed gap, and the number of reads is capped. For most manufacturer IDs, bit 5 of a non-matching read is taken as the device's own timeout flag. All delays are counted in clock cycles set by parameters. Bit 16 of every flash address goes out on a separate bank-select pin; the lower 16 bits go on the address bus.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program operation (op code 0) writes exactly four cycles as {address, data}: {05555h, AAh}, {02AAAh, 55h}, {05555h, A0h}, {target, data byte}.
- R2: An erase operation (op code 1) writes exactly six cycles: {05555h, AAh}, {02AAAh, 55h}, {05555h, 80h}, {05555h, AAh}, {02AAAh, 55h}, then {target AND sector mask, opcode}. The opcode is 10h when the manufacturer ID is DAh and 30h for any other ID.
- R3: An ID-read operation (op code 2) writes {05555h, AAh}, {02AAAh, 55h}, {05555h, 90h}. It then makes exactly one read at address 00001h and returns the read byte on id_byte, together with a done pulse and no error.
- R4: fl_bank carries bit 16 and fl_addr carries bits 15:0 of the 17-bit address of every write and read cycle. The unlock cycles therefore have fl_bank low. Program and erase polls read the unmasked target address.
- R5: After a program or erase, the block reads the target until bit 7 of the read byte equals the expected bit 7 (the data byte's bit 7 for a program, 1 for an erase). The first matching read ends the operation with done and no error, whatever bit 5 of that read is.
- R6: If the manufacturer ID is neither 40h nor DAh, a non-matching read with bit 5 set allows exactly one further read. If that read does not match either, the operation ends with error. For IDs 40h and DAh, bit 5 has no effect.
- R7: After a program, the first poll read is in the cycle right after the last write. After an erase, it is ERASE_WAIT+1 cycles after the last write. Consecutive poll reads are POLL_GAP+2 cycles apart.
- R8: If MAX_POLLS reads all fail to match, the operation ends with error after exactly MAX_POLLS reads.
- R9: start is accepted only while busy is low and op is not 3; op code 3 and any start while busy are ignored. busy is high from the first write cycle until the operation ends. done and error are one-cycle pulses that are never high together, and each coincides with the first cycle in which busy is low again.
- R10: After reset, busy, done, error, fl_we and fl_re are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 program, 1 sector erase, 2 ID read, 3 ignored |
| addr | input | 17 | Target flash address |
| wdata | input | 8 | Byte to program |
| sec_mask | input | 17 | Mask ANDed with the target for the erase cycle |
| mfr_id | input | 8 | Manufacturer ID of the attached device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse |
| id_byte | output | 8 | Byte returned by the last ID read |
| fl_addr | output | 16 | Flash address bits 15:0 |
| fl_bank | output | 1 | Flash address bit 16 |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Write cycle strobe |
| fl_re | output | 1 | Read cycle strobe; data is expected in the next cycle |
| fl_rdata | input | 8 | Low byte of the flash read word |

## Verification
The bench sweeps program and erase over four manufacturer IDs: two that honour bit 5 and the two exempt ones. Each combination is run with 0 to MAX_POLLS non-matching reads, with bit 5 never, always or late in the non-matching reads, and with both values of the data byte's top bit. This separates success on the first matching read from failure after one extra read on bit 5, from exhaustion of the poll budget, and from the exempt IDs ignoring bit 5. The target's bit 16 alternates between runs, so the bank output and the masked erase address are both exercised. The erase run on ID DAh tells the two erase opcodes apart. ID reads with several returned bytes check id_byte. Starts issued while busy, and op code 3, check that they leave the write log and the outputs untouched.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int FA_W = 17;

    localparam logic [FA_W-1:0] UNLOCK_A1 = 17'h05555;
    localparam logic [FA_W-1:0] UNLOCK_A2 = 17'h02AAA;
    localparam logic [FA_W-1:0] ID_ADDR   = 17'h00001;

    localparam logic [7:0] KEY_1      = 8'hAA;
    localparam logic [7:0] KEY_2      = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] SECT_ALT   = 8'h10;
    localparam logic [7:0] SECT_STD   = 8'h30;
    localparam logic [7:0] MID_ALT    = 8'hDA;
    localparam logic [7:0] MID_NOFLAG = 8'h40;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_ERASE = 2'd1,
        OP_ID    = 2'd2,
        OP_NONE  = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_WAIT, S_RD, S_RCAP, S_GAP
    } fstate_e;

    typedef struct packed {
        logic [FA_W-1:0] addr;
        logic [7:0]      data;
    } bus_cyc_t;

    function automatic logic [2:0] last_step(fop_e op);
        case (op)
            OP_PROG:  return 3'd3;
            OP_ERASE: return 3'd5;
            default:  return 3'd2;
        endcase
    endfunction

    function automatic bit dq5_exempt(logic [7:0] id);
        return (id == MID_ALT) || (id == MID_NOFLAG);
    endfunction

    function automatic bus_cyc_t cmd_cycle(fop_e op, logic [2:0] step,
                                           logic [FA_W-1:0] tgt, logic [7:0] d,
                                           logic [FA_W-1:0] mask, logic [7:0] id);
        bus_cyc_t c;
        case (step)
            3'd0: c = '{UNLOCK_A1, KEY_1};
            3'd1: c = '{UNLOCK_A2, KEY_2};
            3'd2: begin
                c.addr = UNLOCK_A1;
                case (op)
                    OP_PROG:  c.data = CMD_PROG;
                    OP_ERASE: c.data = CMD_ERASE;
                    default:  c.data = CMD_ID;
                endcase
            end
            3'd3: c = (op == OP_PROG) ? '{tgt, d} : '{UNLOCK_A1, KEY_1};
            3'd4: c = '{UNLOCK_A2, KEY_2};
            default: c = '{tgt & mask, (id == MID_ALT) ? SECT_ALT : SECT_STD};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fcs_cmd_gen.sv
module fcs_cmd_gen
    import flash_seq_pkg::*;
(
    input  fop_e            op,
    input  logic [2:0]      step,
    input  logic [FA_W-1:0] tgt,
    input  logic [7:0]      data,
    input  logic [FA_W-1:0] mask,
    input  logic [7:0]      id,
    output bus_cyc_t        cyc,
    output logic            last
);
    always_comb begin
        cyc  = cmd_cycle(op, step, tgt, data, mask, id);
        last = (step == last_step(op));
    end
endmodule

// File: rtl/fcs_delay.sv
module fcs_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fcs_poll_judge.sv
module fcs_poll_judge (
    input  logic [7:0] rbyte,
    input  logic       exp7,
    input  logic       exempt,
    input  logic       seen,
    input  logic       at_limit,
    output logic       hit,
    output logic       fail,
    output logic       mark
);
    always_comb begin
        hit  = (rbyte[7] == exp7);
        fail = !hit && (seen || at_limit);
        mark = !hit && !exempt && rbyte[5];
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ERASE_WAIT = 18750,
    parameter int POLL_GAP   = 1250,
    parameter int MAX_POLLS  = 3000000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic [FA_W-1:0] addr,
    input  logic [7:0]      wdata,
    input  logic [FA_W-1:0] sec_mask,
    input  logic [7:0]      mfr_id,
    output logic            busy,
    output logic            done,
    output logic            error,
    output logic [7:0]      id_byte,
    output logic [FA_W-2:0] fl_addr,
    output logic            fl_bank,
    output logic [7:0]      fl_wdata,
    output logic            fl_we,
    output logic            fl_re,
    input  logic [7:0]      fl_rdata
);
    localparam int DLY_MAX = (ERASE_WAIT > POLL_GAP) ? ERASE_WAIT : POLL_GAP;
    localparam int DLY_W   = $clog2(DLY_MAX + 1);
    localparam int PC_W    = $clog2(MAX_POLLS + 1);

    fstate_e         state;
    fop_e            op_q;
    logic [FA_W-1:0] addr_q;
    logic [FA_W-1:0] mask_q;
    logic [7:0]      data_q;
    logic [7:0]      id_q;
    logic [2:0]      step;
    logic [PC_W-1:0] poll_cnt;
    logic            seen;

    bus_cyc_t   cyc;
    bus_cyc_t   port_cyc;
    logic       last;
    logic       hit, fail, mark;
    logic       go_wait, go_gap, dly_zero, dly_load;
    logic [DLY_W-1:0] dly_val;

    fcs_cmd_gen u_gen (
        .op(op_q), .step(step), .tgt(addr_q), .data(data_q),
        .mask(mask_q), .id(id_q), .cyc(cyc), .last(last)
    );

    fcs_poll_judge u_judge (
        .rbyte(fl_rdata),
        .exp7((op_q == OP_ERASE) ? CMD_ERASE[7] : data_q[7]),
        .exempt(dq5_exempt(id_q)),
        .seen(seen),
        .at_limit(poll_cnt == PC_W'(MAX_POLLS)),
        .hit(hit), .fail(fail), .mark(mark)
    );

    always_comb begin
        go_wait  = (state == S_CMD) && last && (op_q == OP_ERASE);
        go_gap   = (state == S_RCAP) && (op_q != OP_ID) && !hit && !fail;
        dly_load = go_wait || go_gap;
        dly_val  = go_wait ? DLY_W'(ERASE_WAIT - 1) : DLY_W'(POLL_GAP - 1);
    end

    fcs_delay #(.W(DLY_W)) u_dly (
        .clk(clk), .rst(rst), .load(dly_load), .val(dly_val), .zero(dly_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_NONE;
            addr_q   <= '0;
            mask_q   <= '0;
            data_q   <= '0;
            id_q     <= '0;
            step     <= '0;
            poll_cnt <= '0;
            seen     <= 1'b0;
            done     <= 1'b0;
            error    <= 1'b0;
            id_byte  <= '0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start && fop_e'(op) != OP_NONE) begin
                        op_q     <= fop_e'(op);
                        addr_q   <= addr;
                        mask_q   <= sec_mask;
                        data_q   <= wdata;
                        id_q     <= mfr_id;
                        step     <= '0;
                        poll_cnt <= '0;
                        seen     <= 1'b0;
                        state    <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (last)
                        state <= (op_q == OP_ERASE) ? S_WAIT : S_RD;
                    else
                        step <= step + 1'b1;
                end
                S_WAIT, S_GAP: begin
                    if (dly_zero)
                        state <= S_RD;
                end
                S_RD: begin
                    poll_cnt <= poll_cnt + 1'b1;
                    state    <= S_RCAP;
                end
                S_RCAP: begin
                    if (op_q == OP_ID) begin
                        id_byte <= fl_rdata;
                        done    <= 1'b1;
                        state   <= S_IDLE;
                    end else if (hit) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else if (fail) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        seen  <= seen | mark;
                        state <= S_GAP;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy  = (state != S_IDLE);
        fl_we = (state == S_CMD);
        fl_re = (state == S_RD);
        if (state == S_CMD)
            port_cyc = cyc;
        else
            port_cyc = '{(op_q == OP_ID) ? ID_ADDR : addr_q, 8'h00};
        fl_addr  = port_cyc.addr[FA_W-2:0];
        fl_bank  = port_cyc.addr[FA_W-1];
        fl_wdata = fl_we ? port_cyc.data : 8'h00;
    end
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [1:0]  op,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic [15:0] fl_addr,
    input logic        fl_bank,
    input logic [7:0]  fl_wdata,
    input logic        fl_we,
    input logic        fl_re
);
    assert_first_unlock_R4: assert property (@(posedge clk) disable iff (rst)
        $past(start && !busy && op != 2'b11 && !rst)
        |-> (fl_we && fl_addr == 16'h5555 && fl_wdata == 8'hAA && !fl_bank));

    assert_end_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_error_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);

    assert_busy_release_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || error));

    assert_access_in_op_R9: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_re) |-> (busy && !(fl_we && fl_re)));
endmodule

bind flash_cmd_seq fcs_checker u_fcs_checker (.*);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int EW = 6;
    localparam int PG = 3;
    localparam int MP = 5;
    localparam int LOGN = 4096;

    logic clk = 1'b0;
    logic rst;
    always #4 clk = ~clk;

    logic        start;
    logic [1:0]  op;
    logic [16:0] addr;
    logic [7:0]  wdata;
    logic [16:0] sec_mask;
    logic [7:0]  mfr_id;
    logic        busy, done, error;
    logic [7:0]  id_byte;
    logic [15:0] fl_addr;
    logic        fl_bank;
    logic [7:0]  fl_wdata;
    logic        fl_we, fl_re;
    logic [7:0]  fl_rdata;

    flash_cmd_seq #(.ERASE_WAIT(EW), .POLL_GAP(PG), .MAX_POLLS(MP)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .sec_mask(sec_mask), .mfr_id(mfr_id), .busy(busy), .done(done),
        .error(error), .id_byte(id_byte), .fl_addr(fl_addr), .fl_bank(fl_bank),
        .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
    );

    int total = 0;
    int bad = 0;

    // flash model and access log
    int          cyc = 0;
    int          wr_n = 0, rd_n = 0, rd_base = 0;
    logic [16:0] wr_a [LOGN];
    logic [7:0]  wr_d [LOGN];
    int          wr_t [LOGN];
    logic [16:0] rd_a [LOGN];
    int          rd_t [LOGN];
    int          m_fail = 0, m_dq5 = 99;
    logic [7:0]  m_match = 8'h00;
    logic [15:0] word16;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (fl_we) begin
            if (wr_n < LOGN) begin
                wr_a[wr_n] <= {fl_bank, fl_addr};
                wr_d[wr_n] <= fl_wdata;
                wr_t[wr_n] <= cyc;
            end
            wr_n <= wr_n + 1;
        end
        if (fl_re) begin
            if (rd_n < LOGN) begin
                rd_a[rd_n] <= {fl_bank, fl_addr};
                rd_t[rd_n] <= cyc;
            end
            if (rd_n - rd_base < m_fail)
                word16 = {8'hC3, ~m_match[7], 1'b0, (rd_n - rd_base >= m_dq5), 5'h05};
            else
                word16 = {8'h5A, m_match};
            fl_rdata <= word16[7:0];
            rd_n <= rd_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    // expected poll outcome from R5, R6, R8
    task automatic expect_poll(input bit exempt, input int fail, input int dq5,
                               output int reads, output bit err, output bit lim);
        bit seen = 0;
        lim = 0;
        for (int k = 0; k < 64; k++) begin
            if (k >= fail) begin reads = k + 1; err = 0; return; end
            if (seen) begin reads = k + 1; err = 1; return; end
            if (k + 1 == MP) begin reads = k + 1; err = 1; lim = 1; return; end
            if (k >= dq5 && !exempt) seen = 1;
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [16:0] a, input logic [7:0] d,
                          input logic [16:0] m, input logic [7:0] id,
                          input int fail, input int dq5, input logic [7:0] idval,
                          input bit intrude);
        int wb, rb, n, nw, ereads;
        bit eerr, elim, exempt;
        logic [16:0] ea [6];
        logic [7:0]  ed [6];
        string rtag;
        wb = wr_n;
        rb = rd_n;
        rd_base = rd_n;
        exempt = (id == 8'hDA) || (id == 8'h40);
        if (o == 2'd2) begin
            m_fail = 0; m_dq5 = 99; m_match = idval;
            ereads = 1; eerr = 0; elim = 0; nw = 3;
            ea[0] = 17'h05555; ed[0] = 8'hAA;
            ea[1] = 17'h02AAA; ed[1] = 8'h55;
            ea[2] = 17'h05555; ed[2] = 8'h90;
            rtag = "R3";
        end else begin
            m_fail = fail; m_dq5 = dq5;
            m_match = {(o == 2'd1) ? 1'b1 : d[7], 7'h3A};
            expect_poll(exempt, fail, dq5, ereads, eerr, elim);
            ea[0] = 17'h05555; ed[0] = 8'hAA;
            ea[1] = 17'h02AAA; ed[1] = 8'h55;
            if (o == 2'd0) begin
                nw = 4; rtag = "R1";
                ea[2] = 17'h05555; ed[2] = 8'hA0;
                ea[3] = a;         ed[3] = d;
            end else begin
                nw = 6; rtag = "R2";
                ea[2] = 17'h05555; ed[2] = 8'h80;
                ea[3] = 17'h05555; ed[3] = 8'hAA;
                ea[4] = 17'h02AAA; ed[4] = 8'h55;
                ea[5] = a & m;     ed[5] = (id == 8'hDA) ? 8'h10 : 8'h30;
            end
        end
        @(negedge clk);
        op = o; addr = a; wdata = d; sec_mask = m; mfr_id = id; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && fl_we, "R9 busy on first write", {busy, fl_we}, 3);
        n = 0;
        while (!(done || error) && n < 200) begin
            @(negedge clk);
            n++;
            if (intrude && n == 2) begin op = 2'd0; addr = 17'h1FFFF; wdata = 8'h11; start = 1'b1; end
            if (intrude && n == 3) start = 1'b0;
            if (!(done || error))
                chk(busy, "R9 busy held", busy, 1);
        end
        if (n >= 200) chk(0, "watchdog op", n, 0);
        if (eerr)
            chk(error && !done && !busy, elim ? "R8 error end" : "R6 error end",
                {error, done, busy}, 4);
        else
            chk(done && !error && !busy, (o == 2'd2) ? "R3 done end" : "R5 done end",
                {error, done, busy}, 2);
        if (o == 2'd2)
            chk(id_byte == idval, "R3 id byte", id_byte, idval);
        chk(wr_n - wb == nw, {rtag, " write count"}, wr_n - wb, nw);
        for (int i = 0; i < nw && i < wr_n - wb; i++) begin
            chk(wr_a[wb+i] == ea[i], {rtag, " R4 write addr/bank"}, wr_a[wb+i], ea[i]);
            chk(wr_d[wb+i] == ed[i], {rtag, " write data"}, wr_d[wb+i], ed[i]);
        end
        chk(rd_n - rb == ereads, elim ? "R8 read count" : "R5 R6 read count",
            rd_n - rb, ereads);
        for (int i = 0; i < ereads && i < rd_n - rb; i++) begin
            if (o == 2'd2)
                chk(rd_a[rb+i] == 17'h00001, "R3 read addr", rd_a[rb+i], 1);
            else
                chk(rd_a[rb+i] == a, "R4 poll addr/bank", rd_a[rb+i], a);
            if (i == 0 && o != 2'd2)
                chk(rd_t[rb] - wr_t[wb+nw-1] == ((o == 2'd1) ? EW + 1 : 1),
                    "R7 first poll delay", rd_t[rb] - wr_t[wb+nw-1],
                    (o == 2'd1) ? EW + 1 : 1);
            if (i > 0)
                chk(rd_t[rb+i] - rd_t[rb+i-1] == PG + 2, "R7 poll spacing",
                    rd_t[rb+i] - rd_t[rb+i-1], PG + 2);
        end
        @(negedge clk);
        chk(!done && !error, "R9 single pulse", {done, error}, 0);
    endtask

    logic [7:0] ids [4];
    logic [7:0] idvals [4];
    int ii;
    int wsave;

    initial begin
        ids[0] = 8'h6D; ids[1] = 8'h40; ids[2] = 8'hDA; ids[3] = 8'hBF;
        idvals[0] = 8'h00; idvals[1] = 8'hFF; idvals[2] = 8'h6D; idvals[3] = 8'hDA;
        ii = 0;
        rst = 1'b1; start = 1'b0; op = 2'd0; addr = '0; wdata = '0;
        sec_mask = '0; mfr_id = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !error && !fl_we && !fl_re, "R10 reset state",
            {busy, done, error, fl_we, fl_re}, 0);

        // op code 3 is ignored
        wsave = wr_n;
        op = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) begin
            @(negedge clk);
            chk(!busy && !fl_we && !fl_re, "R9 op3 ignored", {busy, fl_we, fl_re}, 0);
        end
        chk(wr_n == wsave, "R9 op3 no writes", wr_n - wsave, 0);

        for (int o = 0; o < 2; o++)
            for (int k = 0; k < 4; k++)
                for (int f = 0; f <= MP; f++)
                    for (int q = 0; q < 3; q++)
                        for (int b = 0; b < 2; b++) begin
                            run_op(2'(o), {ii[0], 16'(16'h3C5A + ii * 16'h0101)},
                                   {b[0], 7'(ii * 3)}, 17'h1F000, ids[k], f,
                                   (q == 0) ? 99 : ((q == 1) ? 0 : 2), 8'h00, 1'b0);
                            ii++;
                        end

        for (int k = 0; k < 4; k++)
            run_op(2'd2, 17'h10000, 8'h00, 17'h1F000, ids[k], 0, 99, idvals[k], 1'b0);

        // starts during an operation are ignored
        run_op(2'd1, 17'h1ABCD, 8'h00, 17'h1E000, 8'hBF, 2, 99, 8'h00, 1'b1);
        run_op(2'd2, 17'h00000, 8'h00, 17'h1F000, 8'h6D, 0, 99, 8'hA7, 1'b1);

        finish_run();
    end
endmodule